// File: doc/BRIEF.md
# Serial NAND Status and Protection Register Bank

This block holds the three 8-bit control registers of a serial NAND device: a protection register, a configuration register and a status register. A host-side write port updates the first two, and a combinational read port returns any of the three. A command decoder elsewhere in the device sends single-cycle pulses for write-enable, program start and end, erase start and end, soft reset and ECC results. The block applies those pulses to the status bits.

The protection and configuration fields are also brought out as level outputs, so the array controller can act on them. These fields are the block-protect field, the protected-end select, the hardware protect mode, ECC enable, buffered read mode, OTP access, the OTP write block and the protection lock. Two lock bits are sticky, and one of them permanently freezes the protection register. The failure flags are cleared when an operation starts. The ECC result bits are cleared only by a reset.

All register updates take effect on the clock edge after the pulse or write. Reads are combinational from the current register state.

Top module: `nand_sreg_bank`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the protection register reads 0x78, the configuration register reads 0x10 plus 0x08 when BUF_INIT is 1, and the status register reads 0x00. Read select values are 0 for protection, 1 for configuration, 2 for status and 3 for a constant 0.
- R2: A host write to the protection register (select 0) stores bits 6:1 of the data, and bits 7 and 0 read 0. The write is ignored while the device is busy (status bit 0) or while the protection lock (configuration bit 5) is set.
- R3: With protection bit 1 at 0 (software mode) the wp_n pin has no effect on protection writes. With bit 1 at 1 a protection write is ignored while wp_n is low.
- R4: A host write to the configuration register (select 1) stores bits 7:3, and bits 2:0 always read 0. The write is ignored while busy. Bit 7 (OTP lock) and bit 5 (protection lock) cannot be cleared once set, except by reset.
- R5: Host writes with select 2 leave the status register unchanged.
- R6: A write-enable pulse sets status bit 1 when the device is not busy.
- R7: A program start or erase start pulse is accepted only while status bit 1 is set and bit 0 is clear. An accepted pulse sets bit 0 and clears bits 3 and 2. If both starts arrive in the same cycle, program wins.
- R8: The end pulse that matches the running operation clears status bits 0 and 1. A program end loads its fail input into bit 3, and an erase end loads its fail input into bit 2. An end pulse for the other operation is ignored.
- R9: An ECC result pulse loads the 2-bit code into status bits 5:4, with bit 5 marking an uncorrectable read. These bits are kept through operation starts and ends.
- R10: A soft reset pulse clears status bits 5:0 and aborts a running operation. It leaves the protection and configuration registers unchanged.
- R11: The level outputs mirror the register fields at all times. These are blk_protect = prot[6:3], prot_low_end = prot[2], hw_protect_mode = prot[1], otp_write_block = cfg[7], otp_access = cfg[6], prot_locked = cfg[5], ecc_enable = cfg[4], buf_mode = cfg[3], dev_busy = stat[0] and wel = stat[1].
- R12: Status bit 6 shows the lut_full input as registered one clock earlier, and status bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register targeted by the write |
| host_wdata | input | 8 | Write data |
| host_rsel | input | 2 | Register shown on host_rdata |
| host_rdata | output | 8 | Read data |
| cmd_wr_enable | input | 1 | Write-enable command pulse |
| cmd_soft_reset | input | 1 | Soft reset command pulse |
| pgm_start | input | 1 | Program operation start pulse |
| pgm_done | input | 1 | Program operation end pulse |
| pgm_fail | input | 1 | Program failed, qualifies pgm_done |
| ers_start | input | 1 | Erase operation start pulse |
| ers_done | input | 1 | Erase operation end pulse |
| ers_fail | input | 1 | Erase failed, qualifies ers_done |
| ecc_valid | input | 1 | ECC result pulse |
| ecc_result | input | 2 | ECC result code |
| lut_full | input | 1 | All remap table entries used |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| blk_protect | output | 4 | Block-protect field |
| prot_low_end | output | 1 | Protection applies from the low end |
| hw_protect_mode | output | 1 | Hardware protect mode selected |
| ecc_enable | output | 1 | On-device ECC enabled |
| buf_mode | output | 1 | Buffered read mode |
| otp_access | output | 1 | OTP area access enabled |
| otp_write_block | output | 1 | OTP area permanently write-blocked |
| prot_locked | output | 1 | Protection register frozen |
| dev_busy | output | 1 | Operation in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The bench runs directed sequences first. Protection writes are tried with wp_n low in both modes, which separates pin gating from lock gating. Write-enable, start and end pulses are tried in legal and illegal orders, such as a start without the latch, a start while busy, a mismatched end, and both starts in one cycle. These show which status bits each pulse may touch. ECC codes are loaded before operations and after them, which separates the ECC bits' retention from the fail flags' clear-on-start. A long phase of random pulses and writes then mixes every event in the same cycle. A cycle-level model checks the outputs and the rotating read port on every clock.

// File: rtl/nsr_pkg.sv
// Package: shared widths, selector and operation encodings, bit positions
// and reset values for the NAND register bank.
package nsr_pkg;
    localparam int REG_W = 8;
    localparam int SEL_W = 2;
    localparam int BP_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_PROT = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_kind_e;

    // protection register
    localparam int P_BP_LO   = 3;
    localparam int P_LOW_END = 2;
    localparam int P_HW_MODE = 1;
    // configuration register
    localparam int C_OTP_LOCK  = 7;
    localparam int C_OTP_EN    = 6;
    localparam int C_PROT_LOCK = 5;
    localparam int C_ECC_EN    = 4;
    localparam int C_BUF       = 3;
    // status register
    localparam int S_LUT   = 6;
    localparam int S_ECC_HI = 5;
    localparam int S_ECC_LO = 4;
    localparam int S_PFAIL = 3;
    localparam int S_EFAIL = 2;
    localparam int S_WEL   = 1;
    localparam int S_BUSY  = 0;

    localparam logic [REG_W-1:0] PROT_RST    = 8'h78;
    localparam logic [REG_W-1:0] PROT_WMASK  = 8'h7E;
    localparam logic [REG_W-1:0] CFG_BASE    = 8'h10;
    localparam logic [REG_W-1:0] CFG_WMASK   = 8'hF8;
    localparam logic [REG_W-1:0] CFG_STICKY  = 8'hA0;
endpackage

// File: rtl/nsr_prot_reg.sv
// Protection register. Holds the block-protect field, protected-end select
// and protect mode. Assumes wr_hit is a one-cycle host write strobe already
// decoded for this register; lock comes from the configuration register.
module nsr_prot_reg
    import nsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wr_data,
    input  logic             lock,
    input  logic             busy,
    input  logic             wp_n,
    output logic [REG_W-1:0] q
);
    logic pin_blocks;
    logic accept;

    // pin gating applies only in hardware protect mode
    assign pin_blocks = q[P_HW_MODE] & ~wp_n;
    assign accept     = wr_hit & ~busy & ~lock & ~pin_blocks;

    // register update: reset default or gated host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= PROT_RST;
        end else if (accept) begin
            q <= wr_data & PROT_WMASK;
        end
    end

    // R2
    prot_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(q));

    // R3
    prot_sw_mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !busy && !lock && !q[P_HW_MODE])
            |=> (q == ($past(wr_data) & PROT_WMASK)));
endmodule

// File: rtl/nsr_cfg_reg.sv
// Configuration register. Holds the OTP lock and access bits, protection
// lock, ECC enable and buffered read mode. Assumes wr_hit is a one-cycle
// decoded write strobe. The lock bits are sticky until reset.
module nsr_cfg_reg
    import nsr_pkg::*;
#(
    parameter bit BUF_INIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wr_data,
    input  logic             busy,
    output logic [REG_W-1:0] q
);
    localparam logic [REG_W-1:0] BUF_BIT = BUF_INIT ? (REG_W'(1) << C_BUF) : '0;
    localparam logic [REG_W-1:0] CFG_RST = CFG_BASE | BUF_BIT;

    logic accept;
    assign accept = wr_hit & ~busy;

    // register update: new writable bits OR-ed with held sticky bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= CFG_RST;
        end else if (accept) begin
            q <= (wr_data & CFG_WMASK) | (q & CFG_STICKY);
        end
    end

    // R4
    otp_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q[C_OTP_LOCK] |=> q[C_OTP_LOCK]);

    // R4
    prot_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q[C_PROT_LOCK] |=> q[C_PROT_LOCK]);
endmodule

// File: rtl/nsr_stat_reg.sv
// Status register. Tracks busy, the write-enable latch, the program and
// erase failure flags, the ECC result and the table-full flag. Assumes
// all command inputs are single-cycle pulses from the command decoder;
// it has no host write path.
module nsr_stat_reg
    import nsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wren_cmd,
    input  logic             soft_rst,
    input  logic             pgm_start,
    input  logic             pgm_done,
    input  logic             pgm_fail,
    input  logic             ers_start,
    input  logic             ers_done,
    input  logic             ers_fail,
    input  logic             ecc_valid,
    input  logic [1:0]       ecc_code,
    input  logic             lut_full,
    output logic [REG_W-1:0] q
);
    logic       busy_q, wel_q, pfail_q, efail_q, lut_q;
    logic [1:0] ecc_q;
    op_kind_e   kind_q;
    logic       pgm_end_hit, ers_end_hit, start_ok;

    assign pgm_end_hit = busy_q & (kind_q == OP_PROG)  & pgm_done;
    assign ers_end_hit = busy_q & (kind_q == OP_ERASE) & ers_done;
    assign start_ok    = ~busy_q & wel_q;

    // table-full flag: registered copy of the input
    always_ff @(posedge clk) begin
        if (!rst_n) lut_q <= 1'b0;
        else        lut_q <= lut_full;
    end

    // ECC result: loaded on result pulse, cleared only by resets
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) ecc_q <= 2'b00;
        else if (ecc_valid)     ecc_q <= ecc_code;
    end

    // operation sequencing: latch, busy, fail flags, running kind
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            busy_q  <= 1'b0;
            wel_q   <= 1'b0;
            pfail_q <= 1'b0;
            efail_q <= 1'b0;
            kind_q  <= OP_IDLE;
        end else if (pgm_end_hit) begin
            busy_q  <= 1'b0;
            wel_q   <= 1'b0;
            pfail_q <= pgm_fail;
            kind_q  <= OP_IDLE;
        end else if (ers_end_hit) begin
            busy_q  <= 1'b0;
            wel_q   <= 1'b0;
            efail_q <= ers_fail;
            kind_q  <= OP_IDLE;
        end else if (start_ok && (pgm_start || ers_start)) begin
            busy_q  <= 1'b1;
            pfail_q <= 1'b0;
            efail_q <= 1'b0;
            kind_q  <= pgm_start ? OP_PROG : OP_ERASE;
        end else if (!busy_q && wren_cmd) begin
            wel_q   <= 1'b1;
        end
    end

    assign q = {1'b0, lut_q, ecc_q, pfail_q, efail_q, wel_q, busy_q};

    // R7
    start_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q[S_BUSY]) |-> $past(q[S_WEL]));

    // R8
    end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_end_hit || ers_end_hit) |=> (!q[S_BUSY] && !q[S_WEL]));

    // R9
    ecc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_valid && !soft_rst) |=> $stable(q[S_ECC_HI:S_ECC_LO]));
endmodule

// File: rtl/nand_sreg_bank.sv
// Top of the register bank. Decodes host writes, muxes reads and brings
// the control fields out as levels. Assumes host_we and the command inputs
// are synchronous to clk; reads are combinational.
module nand_sreg_bank
    import nsr_pkg::*;
#(
    parameter bit BUF_INIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [SEL_W-1:0] host_sel,
    input  logic [REG_W-1:0] host_wdata,
    input  logic [SEL_W-1:0] host_rsel,
    output logic [REG_W-1:0] host_rdata,
    input  logic             cmd_wr_enable,
    input  logic             cmd_soft_reset,
    input  logic             pgm_start,
    input  logic             pgm_done,
    input  logic             pgm_fail,
    input  logic             ers_start,
    input  logic             ers_done,
    input  logic             ers_fail,
    input  logic             ecc_valid,
    input  logic [1:0]       ecc_result,
    input  logic             lut_full,
    input  logic             wp_n,
    output logic [BP_W-1:0]  blk_protect,
    output logic             prot_low_end,
    output logic             hw_protect_mode,
    output logic             ecc_enable,
    output logic             buf_mode,
    output logic             otp_access,
    output logic             otp_write_block,
    output logic             prot_locked,
    output logic             dev_busy,
    output logic             wel
);
    logic [REG_W-1:0] prot_q, cfg_q, stat_q;
    logic             prot_hit, cfg_hit;

    // write decode per register
    assign prot_hit = host_we & (host_sel == SEL_PROT);
    assign cfg_hit  = host_we & (host_sel == SEL_CFG);

    nsr_prot_reg u_prot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (prot_hit),
        .wr_data (host_wdata),
        .lock    (cfg_q[C_PROT_LOCK]),
        .busy    (stat_q[S_BUSY]),
        .wp_n    (wp_n),
        .q       (prot_q)
    );

    nsr_cfg_reg #(.BUF_INIT(BUF_INIT)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (cfg_hit),
        .wr_data (host_wdata),
        .busy    (stat_q[S_BUSY]),
        .q       (cfg_q)
    );

    nsr_stat_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wren_cmd  (cmd_wr_enable),
        .soft_rst  (cmd_soft_reset),
        .pgm_start (pgm_start),
        .pgm_done  (pgm_done),
        .pgm_fail  (pgm_fail),
        .ers_start (ers_start),
        .ers_done  (ers_done),
        .ers_fail  (ers_fail),
        .ecc_valid (ecc_valid),
        .ecc_code  (ecc_result),
        .lut_full  (lut_full),
        .q         (stat_q)
    );

    // read mux
    always_comb begin
        case (host_rsel)
            SEL_PROT: host_rdata = prot_q;
            SEL_CFG:  host_rdata = cfg_q;
            SEL_STAT: host_rdata = stat_q;
            default:  host_rdata = '0;
        endcase
    end

    assign blk_protect     = prot_q[P_BP_LO +: BP_W];
    assign prot_low_end    = prot_q[P_LOW_END];
    assign hw_protect_mode = prot_q[P_HW_MODE];
    assign otp_write_block = cfg_q[C_OTP_LOCK];
    assign otp_access      = cfg_q[C_OTP_EN];
    assign prot_locked     = cfg_q[C_PROT_LOCK];
    assign ecc_enable      = cfg_q[C_ECC_EN];
    assign buf_mode        = cfg_q[C_BUF];
    assign dev_busy        = stat_q[S_BUSY];
    assign wel             = stat_q[S_WEL];

    // R5
    stat_host_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == SEL_STAT && !cmd_wr_enable && !cmd_soft_reset
         && !pgm_start && !pgm_done && !ers_start && !ers_done && !ecc_valid)
            |=> (stat_q[S_ECC_HI:0] == $past(stat_q[S_ECC_HI:0])));
endmodule

// File: tb/tb_nand_sreg_bank.sv
`timescale 1ns/1ps
module tb_nand_sreg_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 0;
    logic [1:0] host_sel = 0;
    logic [7:0] host_wdata = 0;
    logic [1:0] host_rsel = 0;
    logic [7:0] host_rdata;
    logic       cmd_wr_enable = 0, cmd_soft_reset = 0;
    logic       pgm_start = 0, pgm_done = 0, pgm_fail = 0;
    logic       ers_start = 0, ers_done = 0, ers_fail = 0;
    logic       ecc_valid = 0;
    logic [1:0] ecc_result = 0;
    logic       lut_full = 0, wp_n = 1;
    logic [3:0] blk_protect;
    logic       prot_low_end, hw_protect_mode, ecc_enable, buf_mode;
    logic       otp_access, otp_write_block, prot_locked, dev_busy, wel;

    always #2.5 clk = ~clk;

    nand_sreg_bank dut (.*);

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    bit finished = 0;

    // reference model state: value after the most recent clock edge
    bit [7:0] m_prot, m_cfg, m_stat;
    int m_kind; // 0 idle, 1 program, 2 erase

    task automatic check(string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    function automatic bit [7:0] sel_val(logic [1:0] s);
        case (s)
            2'd0: return m_prot;
            2'd1: return m_cfg;
            2'd2: return m_stat;
            default: return 8'h00;
        endcase
    endfunction

    // model update for the coming edge, from the inputs now applied
    task automatic model_step();
        bit busy;
        if (!rst_n) begin
            m_prot = 8'h78; m_cfg = 8'h18; m_stat = 8'h00; m_kind = 0;
            return;
        end
        busy = m_stat[0];
        if (host_we && !busy) begin
            if (host_sel == 2'd0 && !m_cfg[5] && !(m_prot[1] && !wp_n))
                m_prot = host_wdata & 8'h7E;
            else if (host_sel == 2'd1)
                m_cfg = (host_wdata & 8'hF8) | (m_cfg & 8'hA0);
        end
        m_stat[6] = lut_full;
        if (cmd_soft_reset) begin
            m_stat[5:0] = 6'd0; m_kind = 0;
            return;
        end
        if (ecc_valid) m_stat[5:4] = ecc_result;
        if (busy) begin
            if (m_kind == 1 && pgm_done) begin
                m_stat[0] = 0; m_stat[1] = 0; m_stat[3] = pgm_fail; m_kind = 0;
            end else if (m_kind == 2 && ers_done) begin
                m_stat[0] = 0; m_stat[1] = 0; m_stat[2] = ers_fail; m_kind = 0;
            end
        end else if (m_stat[1] && (pgm_start || ers_start)) begin
            m_stat[0] = 1; m_stat[3] = 0; m_stat[2] = 0;
            m_kind = pgm_start ? 1 : 2;
        end else if (cmd_wr_enable) begin
            m_stat[1] = 1;
        end
    endtask

    // one clock: model, edge, compare, clear pulses, rotate read select
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("rdata", {8'h00, host_rdata}, {8'h00, sel_val(host_rsel)});
        check("levels",
              {3'b0, blk_protect, prot_low_end, hw_protect_mode, otp_write_block,
               otp_access, prot_locked, ecc_enable, buf_mode, dev_busy, wel},
              {3'b0, m_prot[6:3], m_prot[2], m_prot[1], m_cfg[7], m_cfg[6],
               m_cfg[5], m_cfg[4], m_cfg[3], m_stat[0], m_stat[1]});
        host_we = 0; cmd_wr_enable = 0; cmd_soft_reset = 0;
        pgm_start = 0; pgm_done = 0; pgm_fail = 0;
        ers_start = 0; ers_done = 0; ers_fail = 0; ecc_valid = 0;
        host_rsel = host_rsel + 2'd1;
    endtask

    task automatic hwrite(logic [1:0] s, logic [7:0] d);
        host_we = 1; host_sel = s; host_wdata = d; tick();
    endtask

    initial begin
        @(negedge clk);
        // R1: reset defaults
        cur_req = "R1";
        rst_n = 0; tick(); tick();
        rst_n = 1;
        repeat (4) tick();
        // R2: writable bits and reserved ends
        cur_req = "R2";
        hwrite(2'd0, 8'hFF); repeat (3) tick();
        hwrite(2'd0, 8'h00); repeat (3) tick();
        // R3: pin ignored in software mode, honoured in hardware mode
        cur_req = "R3";
        wp_n = 0; hwrite(2'd0, 8'h55); repeat (3) tick();
        wp_n = 1; hwrite(2'd0, 8'h02);
        wp_n = 0; hwrite(2'd0, 8'h78); repeat (3) tick();
        wp_n = 1; hwrite(2'd0, 8'h7A); repeat (3) tick();
        hwrite(2'd0, 8'h30); tick();
        // R4: configuration fields, reserved bits
        cur_req = "R4";
        hwrite(2'd1, 8'h47); repeat (3) tick();
        hwrite(2'd1, 8'h1F); repeat (3) tick();
        // R5: status not writable
        cur_req = "R5";
        hwrite(2'd2, 8'hFF); repeat (3) tick();
        // R7: start without latch ignored
        cur_req = "R7";
        pgm_start = 1; tick(); ers_start = 1; tick(); repeat (2) tick();
        // R6: latch set
        cur_req = "R6";
        cmd_wr_enable = 1; tick(); repeat (2) tick();
        // R9: ECC load before operation
        cur_req = "R9";
        ecc_valid = 1; ecc_result = 2'b10; tick(); repeat (2) tick();
        // R7: accepted program start, then blocked actions while busy
        cur_req = "R7";
        pgm_start = 1; ers_start = 1; tick();
        ers_start = 1; tick(); cmd_wr_enable = 1; tick();
        cur_req = "R2";
        hwrite(2'd0, 8'h7E); hwrite(2'd1, 8'hFF); repeat (2) tick();
        // R8: mismatched end ignored, matching end with failure
        cur_req = "R8";
        ers_done = 1; ers_fail = 1; tick(); tick();
        pgm_done = 1; pgm_fail = 1; tick(); repeat (3) tick();
        // R7: erase start clears program fail; R8: erase fail
        cur_req = "R7";
        cmd_wr_enable = 1; tick(); ers_start = 1; tick(); tick();
        cur_req = "R8";
        pgm_done = 1; tick();
        ers_done = 1; ers_fail = 1; tick(); repeat (2) tick();
        // R9: ECC survives operations; new code loads
        cur_req = "R9";
        cmd_wr_enable = 1; tick(); pgm_start = 1; tick();
        pgm_done = 1; tick(); repeat (2) tick();
        ecc_valid = 1; ecc_result = 2'b01; tick(); repeat (2) tick();
        // R10: soft reset mid-operation
        cur_req = "R10";
        cmd_wr_enable = 1; tick(); ers_start = 1; tick();
        cmd_soft_reset = 1; ecc_valid = 1; ecc_result = 2'b11; tick();
        repeat (3) tick();
        // R12: table-full flag
        cur_req = "R12";
        lut_full = 1; tick(); tick(); lut_full = 0; tick(); tick();
        // R4: locks become sticky, protection frozen
        cur_req = "R4";
        hwrite(2'd1, 8'h20); tick();
        hwrite(2'd1, 8'h00); repeat (2) tick();
        cur_req = "R2";
        hwrite(2'd0, 8'h7E); repeat (3) tick();
        cur_req = "R4";
        hwrite(2'd1, 8'h80); hwrite(2'd1, 8'h00); repeat (3) tick();
        // R11: mixed random traffic
        cur_req = "R11";
        rst_n = 0; tick(); rst_n = 1;
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (i % 997 == 500) rst_n = 0; else rst_n = 1;
            host_we = (r < 20);
            host_sel = 2'($urandom_range(0, 3));
            host_wdata = 8'($urandom);
            host_rsel = 2'($urandom_range(0, 3));
            cmd_wr_enable = ($urandom_range(0, 5) == 0);
            cmd_soft_reset = ($urandom_range(0, 60) == 0);
            pgm_start = ($urandom_range(0, 6) == 0);
            ers_start = ($urandom_range(0, 6) == 0);
            pgm_done = ($urandom_range(0, 5) == 0);
            ers_done = ($urandom_range(0, 5) == 0);
            pgm_fail = 1'($urandom);
            ers_fail = 1'($urandom);
            ecc_valid = ($urandom_range(0, 8) == 0);
            ecc_result = 2'($urandom);
            lut_full = 1'($urandom);
            wp_n = ($urandom_range(0, 3) != 0);
            tick();
        end
        rst_n = 1;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule